// File: doc/BRIEF.md
# Self-Starting Five-State Counter with Seven-Segment Output

This block is a 3-bit synchronous counter. It steps through the fixed, non-binary loop 1, 3, 4, 6, 7 and then returns to 1. All three state bits sit in D-type registers that share one clock edge. The next state is a purely combinational function of the present state.

The three codes outside the loop are 0, 2 and 5. Each of them has its own one-step path into the loop, so any power-up value settles into the loop without outside help.

The present state also drives a BCD-to-seven-segment decoder through the decoder's three low-order inputs, so the display always shows the current state digit. A build-time parameter selects the polarity of the segment lines:

- Common-cathode: a lit segment is 1.
- Common-anode: every segment line is inverted.

The counter is used wherever a small free-running, self-recovering sequence must be shown on a single digit.

Top module: `selfstart_counter_disp`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, the state becomes 1, whatever the value of `en`.
- R2: With `rst` at 0 and `en` at 1, each rising edge moves the state along the loop 1→3→4→6→7→1.
- R3: The next-state function maps the unused codes in one step: 0→1, 2→3 and 5→6. Every code in the loop maps to its successor in the loop.
- R4: With `rst` at 0 and `en` at 0, the state keeps its value across the edge, and the display keeps showing that value.
- R5: In common-cathode polarity (`COMMON_ANODE`=0), `seg_o` holds the pattern {g,f,e,d,c,b,a} for the current state in the same cycle, with 1 meaning lit. The patterns for digits 0..9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R6: With `COMMON_ANODE`=1, every segment line is the bitwise inverse of the common-cathode pattern for the same digit.
- R7: The decoder blanks its output for input codes 10 to 15. The output is 0x00 in common-cathode polarity and 0x7F in common-anode polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset to state 1 |
| en | input | 1 | Count enable; the state holds when low |
| state_o | output | 3 | Present counter state |
| seg_o | output | 7 | Segment lines {g,f,e,d,c,b,a} in the selected polarity |

## Verification
The clocked assertions assume the following about `rst`, `en` and the state:

- `rst` and `en` are stable around each rising edge.
- `rst` is asserted during the first cycles, so the hold and wrap checks never look at an unreset state.
- The unused codes are reached only through the next-state logic and the decoder themselves, not through the top's ports, because the top has no way to load a state.

The bench applies reset from time zero and changes inputs only on falling edges. It covers the unused codes and the blank decoder codes 10 to 15 by driving the next-state unit and the decoder directly across every input value.

// File: rtl/selfstart_counter_pkg.sv
package selfstart_counter_pkg;

    localparam int STATE_W = 3;
    localparam int CODE_W  = 4;
    localparam int SEG_W   = 7;
    localparam int MAX_DIGIT = 9;

    typedef enum logic [STATE_W-1:0] {
        ST_U0 = 3'd0,
        ST_C1 = 3'd1,
        ST_U2 = 3'd2,
        ST_C3 = 3'd3,
        ST_C4 = 3'd4,
        ST_U5 = 3'd5,
        ST_C6 = 3'd6,
        ST_C7 = 3'd7
    } cnt_state_e;

    localparam cnt_state_e FIRST_STATE = ST_C1;

    typedef struct packed {
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_t;

    function automatic cnt_state_e step_state(input cnt_state_e cur);
        cnt_state_e nxt;
        case (cur)
            ST_C1:   nxt = ST_C3;
            ST_C3:   nxt = ST_C4;
            ST_C4:   nxt = ST_C6;
            ST_C6:   nxt = ST_C7;
            ST_C7:   nxt = ST_C1;
            ST_U0:   nxt = ST_C1;
            ST_U2:   nxt = ST_C3;
            ST_U5:   nxt = ST_C6;
            default: nxt = FIRST_STATE;
        endcase
        return nxt;
    endfunction

    function automatic logic in_loop(input cnt_state_e s);
        return (s == ST_C1) || (s == ST_C3) || (s == ST_C4) ||
               (s == ST_C6) || (s == ST_C7);
    endfunction

    function automatic seg_t digit_pattern(input logic [CODE_W-1:0] code);
        seg_t p;
        case (code)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/seq_next_logic.sv
module seq_next_logic
    import selfstart_counter_pkg::*;
(
    input  cnt_state_e cur_i,
    output cnt_state_e nxt_o
);

    always_comb begin
        nxt_o = step_state(cur_i);
    end

    // R3
    always_comb begin
        nxt_in_loop_chk: assert (in_loop(nxt_o));
    end

endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
    import selfstart_counter_pkg::*;
#(
    parameter cnt_state_e RESET_VAL = FIRST_STATE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  cnt_state_e nxt_i,
    output cnt_state_e q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= RESET_VAL;
        end else if (en) begin
            q_o <= nxt_i;
        end
    end

    // R1
    reset_to_first_chk: assert property (@(posedge clk)
        rst |=> (q_o == RESET_VAL));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(rst)) |=> $stable(q_o));

endmodule

// File: rtl/seg7_decoder.sv
module seg7_decoder
    import selfstart_counter_pkg::*;
#(
    parameter bit COMMON_ANODE = 1'b0
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_W-1:0]  seg_o
);

    seg_t lit;

    always_comb begin
        lit = digit_pattern(code_i);
    end

    generate
        if (COMMON_ANODE) begin : g_anode
            assign seg_o = ~lit;
        end else begin : g_cathode
            assign seg_o = lit;
        end
    endgenerate

    // R7
    always_comb begin
        if (code_i > CODE_W'(MAX_DIGIT)) begin
            blank_high_codes_chk: assert ($countones(seg_o ^ {SEG_W{COMMON_ANODE}}) == 0);
        end
    end

endmodule

// File: rtl/selfstart_counter_disp.sv
module selfstart_counter_disp
    import selfstart_counter_pkg::*;
#(
    parameter bit COMMON_ANODE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    output logic [STATE_W-1:0] state_o,
    output logic [SEG_W-1:0]   seg_o
);

    localparam int PAD_W = CODE_W - STATE_W;

    cnt_state_e cur_state;
    cnt_state_e nxt_state;
    logic [CODE_W-1:0] dec_code;

    seq_next_logic u_next (
        .cur_i (cur_state),
        .nxt_o (nxt_state)
    );

    seq_state_reg #(
        .RESET_VAL (FIRST_STATE)
    ) u_reg (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .nxt_i (nxt_state),
        .q_o   (cur_state)
    );

    assign dec_code = {{PAD_W{1'b0}}, cur_state};

    seg7_decoder #(
        .COMMON_ANODE (COMMON_ANODE)
    ) u_dec (
        .code_i (dec_code),
        .seg_o  (seg_o)
    );

    assign state_o = cur_state;

    // R2
    wrap_to_first_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state_o == 3'd7) |=> (state_o == 3'd1));

    // R2
    leave_first_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state_o == 3'd1) |=> (state_o == 3'd3));

    // R5
    seven_three_lit_chk: assert property (@(posedge clk)
        (state_o == 3'd7) |-> ($countones(seg_o ^ {SEG_W{COMMON_ANODE}}) == 3));

endmodule

// File: tb/selfstart_counter_disp_tb.sv
`timescale 1ns/1ps
module selfstart_counter_disp_tb_top;
    import selfstart_counter_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [2:0] st_k, st_a;
    logic [6:0] seg_k, seg_a;

    cnt_state_e nl_cur;
    cnt_state_e nl_nxt;
    logic [3:0] dcode;
    logic [6:0] dseg_k, dseg_a;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    selfstart_counter_disp #(.COMMON_ANODE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .en(en), .state_o(st_k), .seg_o(seg_k));

    selfstart_counter_disp #(.COMMON_ANODE(1'b1)) dut_ca_i (
        .clk(clk), .rst(rst), .en(en), .state_o(st_a), .seg_o(seg_a));

    seq_next_logic nxt_i (.cur_i(nl_cur), .nxt_o(nl_nxt));

    seg7_decoder #(.COMMON_ANODE(1'b0)) dec_k_i (.code_i(dcode), .seg_o(dseg_k));
    seg7_decoder #(.COMMON_ANODE(1'b1)) dec_a_i (.code_i(dcode), .seg_o(dseg_a));

    function automatic logic [6:0] exp_seg(input int d);
        logic a, b, c, dd, e, f, g;
        if (d > 9) return 7'h00;
        a  = !(d == 1 || d == 4);
        b  = !(d == 5 || d == 6);
        c  = (d != 2);
        dd = !(d == 1 || d == 4 || d == 7);
        e  = (d == 0 || d == 2 || d == 6 || d == 8);
        f  = !(d == 1 || d == 2 || d == 3 || d == 7);
        g  = !(d == 0 || d == 1 || d == 7);
        return {g, f, e, dd, c, b, a};
    endfunction

    function automatic int exp_next(input int s);
        int loop_seq [5] = '{1, 3, 4, 6, 7};
        if (s == 0) return 1;
        if (s == 2) return 3;
        if (s == 5) return 6;
        for (int i = 0; i < 5; i++) begin
            if (loop_seq[i] == s) return loop_seq[(i + 1) % 5];
        end
        return -1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req, input int exp_state);
        chk(req, int'(st_k), exp_state);
        chk(req, int'(st_a), exp_state);
        chk("R5", int'(seg_k), int'(exp_seg(exp_state)));
        chk("R6", int'(seg_a), int'(~exp_seg(exp_state) & 7'h7F));
    endtask

    task automatic tick(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        en  = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int model;
        int exp_anode;

        // R1: reset with enable low, then reset overriding enable
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        check_outputs("R1", 1);
        tick(1'b1, 1'b1);
        check_outputs("R1", 1);

        // R2: run the loop several times
        model = 1;
        for (int k = 0; k < 12; k++) begin
            tick(1'b0, 1'b1);
            model = exp_next(model);
            check_outputs("R2", model);
        end

        // R4: enable low holds state and display
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, 1'b0);
            check_outputs("R4", model);
        end

        // R2 and R4: enable alternating
        for (int k = 0; k < 10; k++) begin
            tick(1'b0, k[0]);
            if (k[0]) model = exp_next(model);
            check_outputs(k[0] ? "R2" : "R4", model);
        end

        // R1: reset in the middle of the run
        tick(1'b0, 1'b1);
        model = exp_next(model);
        tick(1'b1, 1'b1);
        model = 1;
        check_outputs("R1", model);

        // R3: every code through the next-state unit
        for (int s = 0; s < 8; s++) begin
            nl_cur = cnt_state_e'(s[2:0]);
            #1;
            chk("R3", int'(nl_nxt), exp_next(s));
        end

        // R5, R6, R7: every decoder code in both polarities
        for (int c = 0; c < 16; c++) begin
            dcode = c[3:0];
            #1;
            exp_anode = int'(~exp_seg(c) & 7'h7F);
            chk(c > 9 ? "R7" : "R5", int'(dseg_k), int'(exp_seg(c)));
            chk(c > 9 ? "R7" : "R6", int'(dseg_a), exp_anode);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule